// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a synchronous memory with two identical ports, left and right. Each port can read or write any location. A collision exists when both ports are enabled on the same address. When that happens, the block gives the location to the port that got there first and raises a busy flag on the other port. A write issued on the busy side is held off. If the losing port keeps its write strobe high, the write lands in the cycle its busy flag drops. Reads are never held off.

A mode pin makes the block a slave. In slave mode the busy flags from an external arbiter arrive on the busy inputs and only gate writes. The block's own arbitration result is then ignored and both busy outputs stay low. This lets several of these blocks share one arbiter.

The arbitration sits in a three-state machine:
- `ARB_IDLE`: no grant is held.
- `ARB_LEFT_WON`: the left port holds the location.
- `ARB_RIGHT_WON`: the right port holds the location.

The transitions are:
- `idle_to_left` and `idle_to_right` are taken when a collision appears. The port whose enable and address were already in place in the previous cycle wins.
- `hold_left` and `hold_right` are taken while the collision persists.
- `release_left` and `release_right` return to idle as soon as the collision ends.

Top module: `twoport_arb_ram`

## Requirements
- R1: A busy output may be high only while both enables are high and both addresses are equal. With different addresses or an idle port, both busy outputs are low.
- R2: At most one busy output is high at a time. The winner is the port whose enable and address were unchanged from the previous cycle while the other port newly arrived. Arrival means either moving onto the matching address or raising its enable. Busy goes to the opposite port in the same cycle the collision appears.
- R3: When both ports reach the collision in the same cycle, parameter `TIE_LEFT` picks the winner. The default, 1, picks the left port, so the right port gets busy.
- R4: The grant is registered. The winner keeps it, and the loser stays busy, for as long as the collision lasts. Busy drops in the same cycle the addresses differ or either enable goes low.
- R5: A write on a port whose busy is high does not change the memory. A write strobe still held when busy drops is stored in that cycle.
- R6: With `slave_mode` high, both busy outputs are low. A high `l_busy_in` or `r_busy_in` blocks that port's writes, and the internal grant has no effect on writes.
- R7: Read data appears one cycle after an enabled cycle and is never blocked by busy. A read of an address written in the same cycle returns the old data. Data written on one port is read on the other port from the next cycle.
- R8: After reset both busy outputs are low, no grant is held and both read data outputs are zero.
- R9: In slave mode, if both ports write the same address unblocked in one cycle, the left port's data is stored.
- R10: With `slave_mode` low, the busy inputs have no effect on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slave_mode | input | 1 | 1: busy comes from the busy inputs; 0: internal arbitration |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write strobe |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, one cycle of latency |
| l_busy_in | input | 1 | External busy for the left port, slave mode only |
| l_busy_out | output | 1 | Left port lost arbitration |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write strobe |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, one cycle of latency |
| r_busy_in | input | 1 | External busy for the right port, slave mode only |
| r_busy_out | output | 1 | Right port lost arbitration |

## Verification
The arbitration is driven with four input patterns, each of which separates a different fault:
- **Left settled first, right arrives by address.** A swapped winner shows up here.
- **Right settled first, left arrives by raising its enable.** A machine that watches addresses but ignores enable edges fails this one.
- **Both ports arrive in the same cycle.** This exposes a wrong tie-break.
- **A long collision in which the loser keeps writing.** This shows whether the grant is held, whether blocked writes leak into memory, and whether the delayed write completes once the match ends.

Slave-mode runs toggle the busy inputs against the internal result to show which one gates the writes. Cross-port reads in the same cycle and in the next cycle separate read-before-write from write-through.

// File: rtl/twoport_pkg.sv
package twoport_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE      = 2'd0,
        ARB_LEFT_WON  = 2'd1,
        ARB_RIGHT_WON = 2'd2
    } arb_state_e;

endpackage

// File: rtl/twoport_port_track.sv
// Remembers what a port presented last cycle and reports whether it is
// unchanged now (the port "was there first" for arbitration purposes).
module twoport_port_track #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);

    logic              prev_en_q;
    logic [ADDR_W-1:0] prev_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_en_q   <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_en_q   <= en;
            prev_addr_q <= addr;
        end
    end

    assign settled = prev_en_q && (prev_addr_q == addr);

endmodule

// File: rtl/twoport_arb_fsm.sv
// Arbitration machine: decides a winner when a collision appears and
// holds it until the collision ends.
module twoport_arb_fsm
    import twoport_pkg::*;
#(
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       collide,
    input  logic       l_settled,
    input  logic       r_settled,
    output logic       left_owns,
    output logic       right_owns,
    output arb_state_e state_q
);

    arb_state_e state_d;
    logic       fresh_left;

    // Winner for a collision that appears this cycle
    always_comb begin
        if (l_settled && !r_settled) begin
            fresh_left = 1'b1;
        end else if (r_settled && !l_settled) begin
            fresh_left = 1'b0;
        end else begin
            fresh_left = TIE_LEFT;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (collide) begin
                    state_d = fresh_left ? ARB_LEFT_WON : ARB_RIGHT_WON; // idle_to_left / idle_to_right
                end
            end
            ARB_LEFT_WON: begin
                state_d = collide ? ARB_LEFT_WON : ARB_IDLE;   // hold_left / release_left
            end
            ARB_RIGHT_WON: begin
                state_d = collide ? ARB_RIGHT_WON : ARB_IDLE;  // hold_right / release_right
            end
            default: begin
                state_d = ARB_IDLE;
            end
        endcase
    end

    // Outputs: effective owner this cycle
    always_comb begin
        left_owns  = 1'b0;
        right_owns = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                left_owns  = collide && fresh_left;
                right_owns = collide && !fresh_left;
            end
            ARB_LEFT_WON: begin
                left_owns  = collide;
            end
            ARB_RIGHT_WON: begin
                right_owns = collide;
            end
            default: begin
                left_owns  = 1'b0;
                right_owns = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/twoport_store.sv
// Storage array with two write ports (left written last, so it wins on a
// shared address) and two registered read ports with read-before-write.
module twoport_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_re,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_re,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (r_we) begin
            cells[r_addr] <= r_wdata;
        end
        if (l_we) begin
            cells[l_addr] <= l_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_re) begin
                l_rdata <= cells[l_addr];
            end
            if (r_re) begin
                r_rdata <= cells[r_addr];
            end
        end
    end

endmodule

// File: rtl/twoport_arb_ram.sv
module twoport_arb_ram
    import twoport_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter bit TIE_LEFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_in,
    output logic              l_busy_out,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_in,
    output logic              r_busy_out
);

    logic       collide;
    logic       l_settled, r_settled;
    logic       left_owns, right_owns;
    logic       l_block, r_block;
    logic       l_we, r_we;
    arb_state_e arb_state;

    assign collide = l_en && r_en && (l_addr == r_addr);

    twoport_port_track #(.ADDR_W(ADDR_W)) u_trk_l (
        .clk(clk), .rst_n(rst_n), .en(l_en), .addr(l_addr), .settled(l_settled)
    );

    twoport_port_track #(.ADDR_W(ADDR_W)) u_trk_r (
        .clk(clk), .rst_n(rst_n), .en(r_en), .addr(r_addr), .settled(r_settled)
    );

    twoport_arb_fsm #(.TIE_LEFT(TIE_LEFT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .collide    (collide),
        .l_settled  (l_settled),
        .r_settled  (r_settled),
        .left_owns  (left_owns),
        .right_owns (right_owns),
        .state_q    (arb_state)
    );

    // Busy out only in master mode; the loser is the non-owner
    assign l_busy_out = !slave_mode && right_owns;
    assign r_busy_out = !slave_mode && left_owns;

    // Write gating source depends on the mode
    assign l_block = slave_mode ? l_busy_in : right_owns;
    assign r_block = slave_mode ? r_busy_in : left_owns;

    assign l_we = l_en && l_wr && !l_block;
    assign r_we = r_en && r_wr && !r_block;

    twoport_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_re    (l_en),
        .l_we    (l_we),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_re    (r_en),
        .r_we    (r_we),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

    logic unused_state;
    assign unused_state = ^arb_state;

endmodule

// File: rtl/twoport_arb_chk.sv
module twoport_arb_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_out,
    input logic              r_busy_out
);

    // R2
    busy_one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy_out && r_busy_out));

    // R1
    l_busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_out |-> (l_en && r_en && (l_addr == r_addr)));

    // R1
    r_busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy_out |-> (l_en && r_en && (l_addr == r_addr)));

    // R6
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (!l_busy_out && !r_busy_out));

    // R4
    l_busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_out |=> (slave_mode || !(l_en && r_en && (l_addr == r_addr)) || l_busy_out));

    // R4
    r_busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy_out |=> (slave_mode || !(l_en && r_en && (l_addr == r_addr)) || r_busy_out));

endmodule

bind twoport_arb_ram twoport_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_twoport_arb_ram.sv
`timescale 1ns/1ps
module sim_twoport_arb_ram;

    localparam int AW = 6;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic          l_en = 0, l_wr = 0, l_busy_in = 0;
    logic          r_en = 0, r_wr = 0, r_busy_in = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_busy_out, r_busy_out;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int         m_owner = 0;        // 0 none, 1 left, 2 right
    bit         pl_en = 0, pr_en = 0;
    int         pl_addr = 0, pr_addr = 0;
    logic [7:0] mem_m [64];
    logic [7:0] exp_lr = 0, exp_rr = 0;

    always #2.5 clk = ~clk;

    twoport_arb_ram u0 (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // One clock: inputs already applied after a falling edge
    task automatic step(string tag);
        bit match, ls, rs, bl, br;
        int fresh, eff;
        #1;
        match = l_en && r_en && (l_addr == r_addr);
        ls = pl_en && (pl_addr == int'(l_addr));
        rs = pr_en && (pr_addr == int'(r_addr));
        if (ls && !rs) fresh = 1;
        else if (rs && !ls) fresh = 2;
        else fresh = 1;                         // default tie-break R3
        eff = (m_owner != 0) ? m_owner : fresh;
        check(tag, "l_busy_out", l_busy_out, !slave_mode && match && eff == 2);
        check(tag, "r_busy_out", r_busy_out, !slave_mode && match && eff == 1);
        bl = slave_mode ? l_busy_in : (match && eff == 2);
        br = slave_mode ? r_busy_in : (match && eff == 1);
        if (l_en) exp_lr = mem_m[l_addr];
        if (r_en) exp_rr = mem_m[r_addr];
        if (r_en && r_wr && !br) mem_m[r_addr] = r_wdata;
        if (l_en && l_wr && !bl) mem_m[l_addr] = l_wdata;   // R9 left last
        m_owner = match ? eff : 0;
        pl_en = l_en; pl_addr = l_addr;
        pr_en = r_en; pr_addr = r_addr;
        @(posedge clk);
        @(negedge clk);
        check(tag, "l_rdata", l_rdata, exp_lr);
        check(tag, "r_rdata", r_rdata, exp_rr);
    endtask

    task automatic setl(bit en, bit wr, int a, int d);
        l_en = en; l_wr = wr; l_addr = AW'(a); l_wdata = DW'(d);
    endtask

    task automatic setr(bit en, bit wr, int a, int d);
        r_en = en; r_wr = wr; r_addr = AW'(a); r_wdata = DW'(d);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        check("R8", "l_busy_out", l_busy_out, 0);
        check("R8", "r_busy_out", r_busy_out, 0);
        check("R8", "l_rdata", l_rdata, 0);
        check("R8", "r_rdata", r_rdata, 0);
        @(negedge clk);

        // fill memory so every read is defined (R1: distinct addresses, no busy)
        for (int i = 0; i < 32; i++) begin
            setl(1, 1, i, i + 8'h10);
            setr(1, 1, i + 32, i + 8'h80);
            step("R1");
        end
        setl(0, 0, 0, 0); setr(0, 0, 0, 0); step("R1");

        // R7 cross-port visibility next cycle
        setl(1, 1, 3, 8'hA5); step("R7");
        setl(0, 0, 3, 0); setr(1, 0, 3, 0); step("R7");
        check("R7", "r_rdata cross", r_rdata, 8'hA5);
        setr(0, 0, 0, 0); step("R7");

        // R3 simultaneous arrival, R7 same-cycle read returns old data
        setl(1, 1, 3, 8'h5A); setr(1, 0, 3, 0); step("R3");
        check("R3", "r_rdata old", r_rdata, 8'hA5);
        setl(0, 0, 0, 0); setr(0, 0, 0, 0); step("R3");

        // R2/R4/R5: left settled first, right arrives by address and writes
        setl(1, 1, 7, 8'h11); setr(1, 1, 9, 8'h22); step("R2");
        setr(1, 1, 7, 8'h33); step("R2");
        for (int i = 0; i < 4; i++) step("R4");
        check("R4", "r_busy held", r_busy_out, 1);
        setl(1, 0, 7, 0); step("R5");            // still colliding, right blocked
        setl(1, 0, 8, 0); step("R5");            // match ends, right write lands
        setl(0, 0, 0, 0); setr(1, 0, 7, 0); step("R5");
        setr(0, 0, 0, 0); step("R5");
        check("R5", "r_rdata after delayed write", r_rdata, 8'h33);

        // R2: right settled first, left arrives by raising its enable
        setr(1, 0, 9, 0); setl(0, 1, 9, 8'h44); step("R2");
        l_en = 1; step("R2");
        check("R2", "l_busy on enable edge", l_busy_out, 1);
        step("R4");
        r_en = 0; step("R4");                    // enable drop releases, left writes
        setl(0, 0, 0, 0); step("R4");
        setl(1, 0, 9, 0); step("R5");
        setl(0, 0, 0, 0); step("R5");
        check("R5", "l_rdata", l_rdata, 8'h44);

        // R10 busy inputs ignored in master mode
        l_busy_in = 1; r_busy_in = 1;
        setl(1, 1, 20, 8'h66); setr(1, 1, 21, 8'h77); step("R10");
        setl(1, 0, 20, 0); setr(1, 0, 21, 0); step("R10");
        check("R10", "l write kept", l_rdata, 8'h66);
        check("R10", "r write kept", r_rdata, 8'h77);

        // R6 slave mode: busy_in gates writes, no busy driven
        slave_mode = 1; l_busy_in = 1; r_busy_in = 0;
        setl(1, 1, 30, 8'hC1); setr(1, 1, 30, 8'hC2); step("R6");
        step("R6");
        l_busy_in = 0; r_busy_in = 1;
        setl(1, 0, 30, 0); setr(1, 1, 30, 8'hC3); step("R6");
        setr(1, 0, 30, 0); step("R6");
        check("R6", "slave read", r_rdata, 8'hC2);
        r_busy_in = 0;

        // R9 simultaneous unblocked slave writes, left wins
        setl(1, 1, 40, 8'hD1); setr(1, 1, 40, 8'hD2); step("R9");
        setl(1, 0, 40, 0); setr(0, 0, 0, 0); step("R9");
        check("R9", "left data stored", l_rdata, 8'hD1);
        slave_mode = 0;
        setl(0, 0, 0, 0); step("R9");

        summary();
        $finish;
    end

endmodule